// File: doc/BRIEF.md
# Sticky Fault Status Capture Register

This block collects asynchronous hardware fault reports into a 64-bit status word. Error detectors raise one line per fault kind, together with the faulting address, a 9-bit data ECC syndrome and a 4-bit tag syndrome. Each kind has a fixed class set by parameter masks: uncorrectable, software-correctable or hardware-corrected. Every accepted report sets its sticky status bit. A multiple-error flag marks repeats of serious faults. The current privilege level is sampled into the word whenever a report is accepted.

A single fault address register and the two syndrome fields describe one event, the highest-priority one that has been logged. A two-state lock machine controls them. In `LOCK_OPEN`, any accepted report is captured (transition *capture*) and the machine moves to `LOCK_HELD`. In `LOCK_HELD`, a strictly higher-ranked report replaces the captured data (transition *overwrite*). Clearing the status bit of the held event returns the machine to `LOCK_OPEN` (transition *release*). In all other cases the machine stays where it is (transition *hold*).

Faults detected on ECC-checked data beats are filtered per transaction: only the first such fault in a multi-beat transfer is kept. Software reads and clears the word through a simple select/read/write port. An interrupt line is raised while any enabled sticky bit is set.

Top module: `fault_status_reg`

## Requirements
- R1: An accepted event on line i sets status bit 33+i (bits 51:33 with the default 19 lines), and the bit stays set until software clears it; reading never changes it.
- R2: A write with `wr_sel`=0 clears each of bits 51:33, 53 and 52 whose data bit is 1 and leaves the others unchanged; a hardware set of a bit in the same cycle as its clear wins.
- R3: The tag syndrome (bits 19:16) and data syndrome (bits 8:0) of the status word ignore writes.
- R4: Bit 63 follows `wr_data[63]` on every status write and is never set by hardware.
- R5: Bit 53 is set when an uncorrectable or software-correctable event is accepted while its own status bit is already set; a repeated hardware-corrected event never sets it. With the default masks, line 1 and line 11 are uncorrectable, line 9 is software-correctable, and lines 0 and 3 are hardware-corrected.
- R6: Bit 52 takes the value of `priv_in` in every cycle in which any event is accepted.
- R7: While the lock is open, an accepted event loads its address (read with `rd_sel`=1, zero-extended) and both syndromes.
- R8: A held capture is replaced only by a strictly higher-ranked event. Ranking: uncorrectable above software-correctable above hardware-corrected, and within a class the higher line number wins.
- R9: Clearing the status bit of the held event reopens capture even if other status bits remain set; the captured values stay readable until the next capture.
- R10: For ECC-filtered lines (default lines 0 to 9 and 12 to 15), only events in the first ECC-faulting beat of a transaction are accepted. A beat is marked by `beat_valid`, and a new transaction starts at `beat_idx`=0. Ignored events set neither a status bit nor bit 53 and do not capture. Other lines are never filtered.
- R11: Several events in one cycle all set their status bits, and the highest-ranked of them is the capture candidate.
- R12: `irq` is high exactly when some status bit is set whose enable bit is set. The enables are written and read with `rd_sel`/`wr_sel`=2 in the low bits, and reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | NUM_ERR | One pulse line per fault kind |
| ev_addr | input | ADDR_W | Fault address for this cycle's events |
| ev_esyn | input | 9 | Data ECC syndrome |
| ev_msyn | input | 4 | Tag ECC syndrome |
| priv_in | input | 1 | Current privileged-mode level |
| beat_valid | input | 1 | A data beat of a transaction is present |
| beat_idx | input | BEAT_W | Beat number within the transaction |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 status, 2 enable |
| wr_data | input | 64 | Write data |
| rd_sel | input | 2 | Read target: 0 status, 1 address, 2 enable |
| rd_data | output | 64 | Read data (combinational) |
| irq | output | 1 | Level interrupt from enabled sticky bits |

## Verification
The bench builds the block with its defaults: 19 fault lines, a 40-bit address, four-beat transactions, and the default class and ECC masks. This puts all three classes within reach, so rank comparisons both inside a class and across classes are exercised. It also leaves two unfiltered lines (10 and 11) next to filtered ones, so filtered and unfiltered events can be driven in the same transaction. Four beats are enough to reach a transaction boundary, to ignore a fault in a later beat, and to accept a fault again after the next beat zero.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic {
        LOCK_OPEN = 1'b0,
        LOCK_HELD = 1'b1
    } lock_state_e;

    localparam int WORD_W    = 64;
    localparam int BIT_SWFLG = 63;
    localparam int BIT_MULTI = 53;
    localparam int BIT_PRIV  = 52;
    localparam int STAT_TOP  = 51;
    localparam int ESYN_W    = 9;
    localparam int MSYN_W    = 4;
    localparam int MSYN_LO   = 16;

    localparam logic [1:0] SEL_STATUS = 2'd0;
    localparam logic [1:0] SEL_ADDR   = 2'd1;
    localparam logic [1:0] SEL_ENABLE = 2'd2;

    localparam int CLS_HW  = 0;
    localparam int CLS_SW  = 1;
    localparam int CLS_UNC = 2;

endpackage

// File: rtl/fsr_beat_filter.sv
module fsr_beat_filter #(
    parameter int              NUM_ERR  = 19,
    parameter int              BEAT_W   = 2,
    parameter logic [NUM_ERR-1:0] ECC_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ERR-1:0] ev_valid,
    input  logic               beat_valid,
    input  logic [BEAT_W-1:0]  beat_idx,
    output logic [NUM_ERR-1:0] ev_acc
);

    logic seen_q;
    logic seen_d;
    logic blocked;
    logic ecc_hit;

    always_comb begin
        blocked = beat_valid && (beat_idx != '0) && seen_q;
        ev_acc  = blocked ? (ev_valid & ~ECC_MASK) : ev_valid;
        ecc_hit = beat_valid && (|(ev_acc & ECC_MASK));
        if (beat_valid) begin
            seen_d = ((beat_idx == '0) ? 1'b0 : seen_q) | ecc_hit;
        end else begin
            seen_d = seen_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= seen_d;
        end
    end

    // R10
    seen_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && (beat_idx != '0) && seen_q) |=> seen_q);

endmodule

// File: rtl/fsr_prio_pick.sv
module fsr_prio_pick #(
    parameter int                 NUM_ERR   = 19,
    parameter logic [NUM_ERR-1:0] UNC_MASK  = '0,
    parameter logic [NUM_ERR-1:0] SWC_MASK  = '0,
    parameter int                 RANK_W    = 6,
    parameter int                 IDX_W     = 5
) (
    input  logic [NUM_ERR-1:0] hits,
    output logic               cand_valid,
    output logic [IDX_W-1:0]   cand_idx,
    output logic [RANK_W-1:0]  cand_rank
);
    import fsr_pkg::*;

    function automatic logic [RANK_W-1:0] rank_of(input int i);
        int cls;
        if (UNC_MASK[i])      cls = CLS_UNC;
        else if (SWC_MASK[i]) cls = CLS_SW;
        else                  cls = CLS_HW;
        return RANK_W'(cls * NUM_ERR + i);
    endfunction

    always_comb begin
        cand_valid = 1'b0;
        cand_idx   = '0;
        cand_rank  = '0;
        for (int i = 0; i < NUM_ERR; i++) begin
            if (hits[i] && (!cand_valid || (rank_of(i) > cand_rank))) begin
                cand_valid = 1'b1;
                cand_idx   = IDX_W'(i);
                cand_rank  = rank_of(i);
            end
        end
    end

endmodule

// File: rtl/fsr_lock_fsm.sv
module fsr_lock_fsm #(
    parameter int NUM_ERR = 19,
    parameter int ADDR_W  = 40,
    parameter int RANK_W  = 6,
    parameter int IDX_W   = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cand_valid,
    input  logic [IDX_W-1:0]          cand_idx,
    input  logic [RANK_W-1:0]         cand_rank,
    input  logic [NUM_ERR-1:0]        stat_q,
    input  logic [NUM_ERR-1:0]        stat_clr,
    input  logic [NUM_ERR-1:0]        ev_acc,
    input  logic [ADDR_W-1:0]         ev_addr,
    input  logic [fsr_pkg::ESYN_W-1:0] ev_esyn,
    input  logic [fsr_pkg::MSYN_W-1:0] ev_msyn,
    output logic [ADDR_W-1:0]         cap_addr,
    output logic [fsr_pkg::ESYN_W-1:0] cap_esyn,
    output logic [fsr_pkg::MSYN_W-1:0] cap_msyn
);
    import fsr_pkg::*;

    lock_state_e        state_q, state_d;
    logic [IDX_W-1:0]   lock_idx_q;
    logic [RANK_W-1:0]  lock_rank_q;
    logic [ADDR_W-1:0]  cap_addr_q;
    logic [ESYN_W-1:0]  cap_esyn_q;
    logic [MSYN_W-1:0]  cap_msyn_q;
    logic               held_clr;
    logic               take;

    always_comb begin
        held_clr = (state_q == LOCK_HELD) && stat_clr[lock_idx_q] && !ev_acc[lock_idx_q];
        take     = 1'b0;
        state_d  = state_q;
        unique case (state_q)
            LOCK_OPEN: begin
                if (cand_valid) begin
                    take    = 1'b1;
                    state_d = LOCK_HELD;
                end
            end
            LOCK_HELD: begin
                if (cand_valid && (held_clr || (cand_rank > lock_rank_q))) begin
                    take    = 1'b1;
                    state_d = LOCK_HELD;
                end else if (held_clr) begin
                    state_d = LOCK_OPEN;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LOCK_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_idx_q  <= '0;
            lock_rank_q <= '0;
            cap_addr_q  <= '0;
            cap_esyn_q  <= '0;
            cap_msyn_q  <= '0;
        end else if (take) begin
            lock_idx_q  <= cand_idx;
            lock_rank_q <= cand_rank;
            cap_addr_q  <= ev_addr;
            cap_esyn_q  <= ev_esyn;
            cap_msyn_q  <= ev_msyn;
        end
    end

    assign cap_addr = cap_addr_q;
    assign cap_esyn = cap_esyn_q;
    assign cap_msyn = cap_msyn_q;

    // R9
    held_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LOCK_HELD) |-> stat_q[lock_idx_q]);

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == LOCK_HELD) && !cand_valid) |=> $stable(cap_addr_q));

endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg #(
    parameter int                 NUM_ERR  = 19,
    parameter int                 ADDR_W   = 40,
    parameter int                 BEATS    = 4,
    parameter logic [NUM_ERR-1:0] UNC_MASK = 19'h75D56,
    parameter logic [NUM_ERR-1:0] SWC_MASK = 19'h00200,
    parameter logic [NUM_ERR-1:0] ECC_MASK = 19'h0F3FF,
    localparam int                BEAT_W   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_ERR-1:0]  ev_valid,
    input  logic [ADDR_W-1:0]   ev_addr,
    input  logic [8:0]          ev_esyn,
    input  logic [3:0]          ev_msyn,
    input  logic                priv_in,
    input  logic                beat_valid,
    input  logic [BEAT_W-1:0]   beat_idx,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [63:0]         wr_data,
    input  logic [1:0]          rd_sel,
    output logic [63:0]         rd_data,
    output logic                irq
);
    import fsr_pkg::*;

    localparam int STAT_LO = STAT_TOP - NUM_ERR + 1;
    localparam int IDX_W   = (NUM_ERR > 1) ? $clog2(NUM_ERR) : 1;
    localparam int RANK_W  = $clog2(3 * NUM_ERR);
    localparam logic [NUM_ERR-1:0] SERIOUS = UNC_MASK | SWC_MASK;

    logic [NUM_ERR-1:0] ev_acc;
    logic               cand_valid;
    logic [IDX_W-1:0]   cand_idx;
    logic [RANK_W-1:0]  cand_rank;
    logic [ADDR_W-1:0]  cap_addr;
    logic [ESYN_W-1:0]  cap_esyn;
    logic [MSYN_W-1:0]  cap_msyn;

    logic [NUM_ERR-1:0] stat_q, stat_d, stat_clr;
    logic [NUM_ERR-1:0] en_q;
    logic               multi_q, multi_d;
    logic               priv_q, priv_d;
    logic               swflg_q, swflg_d;
    logic               wr_status;
    logic               any_acc;
    logic [63:0]        status_word;
    logic               unused_wr;

    fsr_beat_filter #(
        .NUM_ERR (NUM_ERR),
        .BEAT_W  (BEAT_W),
        .ECC_MASK(ECC_MASK)
    ) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_valid  (ev_valid),
        .beat_valid(beat_valid),
        .beat_idx  (beat_idx),
        .ev_acc    (ev_acc)
    );

    fsr_prio_pick #(
        .NUM_ERR (NUM_ERR),
        .UNC_MASK(UNC_MASK),
        .SWC_MASK(SWC_MASK),
        .RANK_W  (RANK_W),
        .IDX_W   (IDX_W)
    ) u_pick (
        .hits      (ev_acc),
        .cand_valid(cand_valid),
        .cand_idx  (cand_idx),
        .cand_rank (cand_rank)
    );

    fsr_lock_fsm #(
        .NUM_ERR(NUM_ERR),
        .ADDR_W (ADDR_W),
        .RANK_W (RANK_W),
        .IDX_W  (IDX_W)
    ) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .cand_valid(cand_valid),
        .cand_idx  (cand_idx),
        .cand_rank (cand_rank),
        .stat_q    (stat_q),
        .stat_clr  (stat_clr),
        .ev_acc    (ev_acc),
        .ev_addr   (ev_addr),
        .ev_esyn   (ev_esyn),
        .ev_msyn   (ev_msyn),
        .cap_addr  (cap_addr),
        .cap_esyn  (cap_esyn),
        .cap_msyn  (cap_msyn)
    );

    always_comb begin
        wr_status = wr_en && (wr_sel == SEL_STATUS);
        any_acc   = |ev_acc;
        stat_clr  = wr_status ? wr_data[STAT_TOP:STAT_LO] : '0;
        stat_d    = (stat_q & ~stat_clr) | ev_acc;
        multi_d   = (|(ev_acc & stat_q & SERIOUS)) |
                    (multi_q & ~(wr_status && wr_data[BIT_MULTI]));
        priv_d    = any_acc ? priv_in : (priv_q & ~(wr_status && wr_data[BIT_PRIV]));
        swflg_d   = wr_status ? wr_data[BIT_SWFLG] : swflg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q  <= '0;
            multi_q <= 1'b0;
            priv_q  <= 1'b0;
            swflg_q <= 1'b0;
            en_q    <= '0;
        end else begin
            stat_q  <= stat_d;
            multi_q <= multi_d;
            priv_q  <= priv_d;
            swflg_q <= swflg_d;
            if (wr_en && (wr_sel == SEL_ENABLE)) begin
                en_q <= wr_data[NUM_ERR-1:0];
            end
        end
    end

    always_comb begin
        status_word                         = '0;
        status_word[BIT_SWFLG]              = swflg_q;
        status_word[BIT_MULTI]              = multi_q;
        status_word[BIT_PRIV]               = priv_q;
        status_word[STAT_TOP:STAT_LO]       = stat_q;
        status_word[MSYN_LO+MSYN_W-1:MSYN_LO] = cap_msyn;
        status_word[ESYN_W-1:0]             = cap_esyn;
    end

    always_comb begin
        unique case (rd_sel)
            SEL_STATUS: rd_data = status_word;
            SEL_ADDR:   rd_data = 64'(cap_addr);
            SEL_ENABLE: rd_data = 64'(en_q);
            default:    rd_data = '0;
        endcase
    end

    assign irq       = |(stat_q & en_q);
    assign unused_wr = ^wr_data;

    // R1
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(stat_q) & ~stat_q & ~$past(stat_clr)) == '0));

    // R5
    multi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(multi_q) |-> $past(|(ev_acc & SERIOUS)));

    // R12
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && (&wr_data[STAT_TOP:STAT_LO]) && !any_acc) |=> !irq);

    // R4
    swflag_hw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_status) |=> $stable(swflg_q));

endmodule

// File: tb/fault_status_reg_tb.sv
module fault_status_reg_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] ev_valid = '0;
    logic [39:0] ev_addr = '0;
    logic [8:0]  ev_esyn = '0;
    logic [3:0]  ev_msyn = '0;
    logic        priv_in = 1'b0;
    logic        beat_valid = 1'b0;
    logic [1:0]  beat_idx = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [63:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [63:0] rd_data;
    logic        irq;

    fault_status_reg u_dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_addr(ev_addr),
        .ev_esyn(ev_esyn), .ev_msyn(ev_msyn), .priv_in(priv_in),
        .beat_valid(beat_valid), .beat_idx(beat_idx), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .irq(irq)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [63:0] exp;
        bit          is_irq;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 0;

    function automatic logic [18:0] b(input int i);
        return 19'(1) << i;
    endfunction

    function automatic logic [63:0] sword(input bit sw, input bit me, input bit pr,
                                          input logic [18:0] st, input logic [3:0] ms,
                                          input logic [8:0] es);
        return {sw, 9'b0, me, pr, st, 13'b0, ms, 7'b0, es};
    endfunction

    localparam logic [63:0] CLR_ALL = {1'b0, 9'b0, 1'b1, 1'b1, 19'h7FFFF, 33'b0};

    // Monitor: pops expected items and compares against the ports.
    initial begin
        forever begin
            item_t it;
            logic [63:0] act;
            wait (sb_q.size() > 0);
            #1;
            it  = sb_q.pop_front();
            act = it.is_irq ? {63'b0, irq} : rd_data;
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic exp_rd(input logic [1:0] sel, input logic [63:0] e, input string tag);
        item_t it;
        rd_sel = sel;
        it.exp = e; it.is_irq = 0; it.tag = tag;
        sb_q.push_back(it);
        #2;
    endtask

    task automatic exp_irq(input bit e, input string tag);
        item_t it;
        it.exp = {63'b0, e}; it.is_irq = 1; it.tag = tag;
        sb_q.push_back(it);
        #2;
    endtask

    task automatic step(input logic [18:0] v, input logic [39:0] a, input logic [8:0] es,
                        input logic [3:0] ms, input bit bv, input logic [1:0] bi,
                        input bit we, input logic [1:0] ws, input logic [63:0] wd);
        @(negedge clk);
        ev_valid = v; ev_addr = a; ev_esyn = es; ev_msyn = ms;
        beat_valid = bv; beat_idx = bi;
        wr_en = we; wr_sel = ws; wr_data = wd;
        @(negedge clk);
        ev_valid = '0; beat_valid = 1'b0; beat_idx = '0; wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic ev(input logic [18:0] v, input logic [39:0] a,
                      input logic [8:0] es, input logic [3:0] ms);
        step(v, a, es, ms, 1'b0, 2'd0, 1'b0, 2'd0, 64'd0);
    endtask

    task automatic bev(input logic [18:0] v, input logic [39:0] a, input logic [8:0] es,
                       input logic [3:0] ms, input logic [1:0] bi);
        step(v, a, es, ms, 1'b1, bi, 1'b0, 2'd0, 64'd0);
    endtask

    task automatic wr(input logic [1:0] ws, input logic [63:0] wd);
        step('0, '0, '0, '0, 1'b0, 2'd0, 1'b1, ws, wd);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_rd(2'd0, 64'd0, "R1 reset status");
        exp_rd(2'd1, 64'd0, "R7 reset address");
        exp_rd(2'd2, 64'd0, "R12 reset enable");
        exp_irq(1'b0, "R12 reset irq");

        // First capture with privilege high
        priv_in = 1'b1;
        ev(b(0), 40'h11_0000_0100, 9'h0A5, 4'h3);
        priv_in = 1'b0;
        exp_rd(2'd0, sword(0, 0, 1, b(0), 4'h3, 9'h0A5), "R1 R6 first event");
        exp_rd(2'd0, sword(0, 0, 1, b(0), 4'h3, 9'h0A5), "R1 read does not clear");
        exp_rd(2'd1, 64'h11_0000_0100, "R7 open capture address");
        exp_irq(1'b0, "R12 no enable");

        wr(2'd2, 64'h7FFFF);
        exp_rd(2'd2, 64'h7FFFF, "R12 enable readback");
        exp_irq(1'b1, "R12 enabled bit set");

        // Hardware-corrected repeat: no multi flag, equal rank no overwrite
        ev(b(0), 40'h22, 9'h1FF, 4'hF);
        exp_rd(2'd0, sword(0, 0, 0, b(0), 4'h3, 9'h0A5), "R5 R6 hw repeat");
        exp_rd(2'd1, 64'h11_0000_0100, "R8 equal rank keeps");

        ev(b(1), 40'h33, 9'h155, 4'h6);
        exp_rd(2'd0, sword(0, 0, 0, b(0) | b(1), 4'h6, 9'h155), "R8 uncorrectable overwrites");
        exp_rd(2'd1, 64'h33, "R8 overwrite address");

        ev(b(9), 40'h44, 9'h044, 4'h4);
        exp_rd(2'd0, sword(0, 0, 0, b(0) | b(1) | b(9), 4'h6, 9'h155), "R8 lower class no overwrite");
        exp_rd(2'd1, 64'h33, "R8 address kept");

        wr(2'd0, 64'(b(0)) << 33);
        exp_rd(2'd0, sword(0, 0, 0, b(1) | b(9), 4'h6, 9'h155), "R2 clear one bit");
        exp_rd(2'd1, 64'h33, "R9 other bit clear keeps lock");

        wr(2'd0, 64'(b(1)) << 33);
        exp_rd(2'd0, sword(0, 0, 0, b(9), 4'h6, 9'h155), "R9 release keeps values");

        ev(b(0), 40'h55, 9'h001, 4'h1);
        exp_rd(2'd1, 64'h55, "R9 reopened capture");
        exp_rd(2'd0, sword(0, 0, 0, b(0) | b(9), 4'h1, 9'h001), "R9 new syndromes");

        ev(b(9), 40'h66, 9'h0F0, 4'h8);
        exp_rd(2'd0, sword(0, 1, 0, b(0) | b(9), 4'h8, 9'h0F0), "R5 sw repeat sets multi");
        exp_rd(2'd1, 64'h66, "R8 sw over hw");

        wr(2'd0, (64'd1 << 63) | 64'h000F_01FF);
        exp_rd(2'd0, sword(1, 1, 0, b(0) | b(9), 4'h8, 9'h0F0), "R3 R4 syndromes read-only flag set");

        wr(2'd0, 64'd0);
        exp_rd(2'd0, sword(0, 1, 0, b(0) | b(9), 4'h8, 9'h0F0), "R2 R4 zero write");

        wr(2'd0, CLR_ALL);
        exp_rd(2'd0, sword(0, 0, 0, 19'd0, 4'h8, 9'h0F0), "R2 clear all");
        exp_irq(1'b0, "R12 irq drops");

        ev(b(0) | b(1) | b(3), 40'h77, 9'h077, 4'h7);
        exp_rd(2'd0, sword(0, 0, 0, b(0) | b(1) | b(3), 4'h7, 9'h077), "R11 all bits set");
        exp_rd(2'd1, 64'h77, "R11 capture");
        exp_irq(1'b1, "R12 irq");

        step(b(1), 40'h88, 9'h188, 4'hC, 1'b0, 2'd0, 1'b1, 2'd0, 64'(b(1)) << 33);
        exp_rd(2'd0, sword(0, 1, 0, b(0) | b(1) | b(3), 4'h7, 9'h077), "R2 R5 set wins over clear");
        exp_rd(2'd1, 64'h77, "R8 lock kept on set-wins");

        wr(2'd0, CLR_ALL);
        wr(2'd2, 64'(b(1)));
        ev(b(0), 40'h99, 9'h099, 4'h9);
        exp_irq(1'b0, "R12 masked bit");
        ev(b(1), 40'hAA, 9'h0AA, 4'hA);
        exp_irq(1'b1, "R12 enabled bit");
        exp_rd(2'd1, 64'hAA, "R8 overwrite");

        wr(2'd0, CLR_ALL);
        bev(b(3), 40'hB0, 9'h0B0, 4'hB, 2'd0);
        bev(b(1), 40'hB1, 9'h1B1, 4'h1, 2'd1);
        exp_rd(2'd0, sword(0, 0, 0, b(3), 4'hB, 9'h0B0), "R10 later beat ignored");
        exp_rd(2'd1, 64'hB0, "R10 no capture");
        bev(b(11), 40'hB2, 9'h0B2, 4'h2, 2'd2);
        exp_rd(2'd0, sword(0, 0, 0, b(3) | b(11), 4'h2, 9'h0B2), "R10 unfiltered accepted");
        bev('0, 40'h0, 9'h0, 4'h0, 2'd3);
        bev(b(1), 40'hB3, 9'h0B3, 4'h3, 2'd0);
        exp_rd(2'd0, sword(0, 0, 0, b(1) | b(3) | b(11), 4'h2, 9'h0B2), "R10 R8 new transaction");
        bev(b(1), 40'hB4, 9'h0B4, 4'h4, 2'd1);
        exp_rd(2'd0, sword(0, 0, 0, b(1) | b(3) | b(11), 4'h2, 9'h0B2), "R10 ignored no multi");
        exp_rd(2'd1, 64'hB2, "R10 address kept");

        wait (sb_q.size() == 0);
        #3;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule